// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a load, a store or an instruction fetch may proceed to a page that has already been translated. It combines three separate checks with a bitwise AND. The first is a protection code paired with a segment key. The second is a no-execute/guarded filter. The third is a pair of per-class key masks. The result is a read/write/execute permission set and a grant.

When an access is refused, every check that contributed to the refusal raises its own cause bit. When an access is granted, the block produces updated referenced and changed bits and asks for a write-back only if those bits differ from their incoming values.

The caller presents one request per cycle with `req_valid`. The response appears one clock later with `rsp_valid`. When no request was presented, all outputs read zero. Carrying out the write-back to memory is the caller's job.

Top module: `pg_perm_eval`

## Requirements
- R1: The key in use is `seg_key_user` when `prob_state` is 1 and `seg_key_sup` when it is 0. The 3-bit protection code is {`pp_hi`, `pp_lo[1:0]`}, so `pp_hi` is bit 2. Permission sets are encoded {exec, write, read} (bit 2 = exec, bit 1 = write, bit 0 = read).
- R2: With key 0, codes 0, 1 and 2 give 111 and codes 3 and 6 give 101. Codes 4, 5 and 7 give 000.
- R3: With key 1, codes 1 and 3 give 101 and code 2 gives 111. Codes 0, 4, 5, 6 and 7 give 000.
- R4: If `no_exec` or `guarded` is 1, the exec bit is removed and read and write are left as they are.
- R5: When `mmu_level` ≥ 1, the data mask is consulted. The pair for class key k sits at bits 2*(31-k)+1 (blocks store/write) and 2*(31-k) (blocks load/read). When `mmu_level` is 0, this mask has no effect.
- R6: When `mmu_level` ≥ 2, a set bit 2*(31-k) of the fetch mask removes exec. When `mmu_level` is 0 or 1, the fetch mask has no effect.
- R7: `acc_type` is encoded 0 = load, 1 = store, 2 = fetch and 3 = load. The grant is the needed bit (read, write or exec) of the ANDed permission set. `rsp_valid` and the results appear exactly one clock after `req_valid`, and all outputs are 0 in a cycle with no response.
- R8: The cause vector is encoded bit 0 = protection, bit 1 = store, bit 2 = class key, bit 3 = no-exec/guard. On a denied fetch:
  - bit 3 is set if the no-execute/guard filter removed exec;
  - otherwise bit 0 is set if the protection code lacked exec;
  - bit 2 is set independently if the fetch mask removed exec.
- R9: On a denied load or store:
  - bit 0 is set if the protection code lacks the needed bit;
  - bit 1 is set for a store;
  - bit 2 is set if the data mask removed the needed bit.
- R10: On a grant, the cause vector is 0 and `ref_out` is 1. `chg_out` is `chg_in` OR (store). For a non-store, the write bit of the reported `perm` is cleared. `wb_req` is 1 only when `ref_out`/`chg_out` differ from `ref_in`/`chg_in`. On a denial, `ref_out`/`chg_out` equal the inputs and `wb_req` is 0, and `perm` reports the ANDed set unchanged.
- R11: While `rst` is high and in the first cycle after it, `rsp_valid`, `grant` and `wb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| prob_state | input | 1 | 1 = user (problem) state |
| seg_key_user | input | 1 | Segment key used in user state |
| seg_key_sup | input | 1 | Segment key used in supervisor state |
| pp_lo | input | 2 | Low two protection-code bits |
| pp_hi | input | 1 | Protection-code bit 2 |
| no_exec | input | 1 | Page no-execute |
| guarded | input | 1 | Page guarded |
| page_ckey | input | KEY_W | Page class key |
| ckey_data_mask | input | 2*2^KEY_W | Load/store class-key mask |
| ckey_fetch_mask | input | 2*2^KEY_W | Fetch class-key mask |
| mmu_level | input | LVL_W | MMU feature level |
| ref_in | input | 1 | Current referenced bit |
| chg_in | input | 1 | Current changed bit |
| rsp_valid | output | 1 | Response present |
| perm | output | 3 | Reported {x,w,r} set |
| grant | output | 1 | Access allowed |
| cause | output | 4 | Fault causes {nxg, ckey, store, prot} |
| ref_out | output | 1 | Updated referenced bit |
| chg_out | output | 1 | Updated changed bit |
| wb_req | output | 1 | Page entry write-back needed |

## Verification
The bench builds the block with its default parameters: a 5-bit class key giving 64-bit masks, class-key checking from level 1, and fetch-mask checking from level 2. With these values both ends of the key-to-bit-pair mapping (key 0 at bits 63:62 and key 31 at bits 1:0) can be reached, along with every level boundary at which a mask starts to count. A table covers all protection codes for both keys. Directed cases then combine several denial sources in a single fetch, so the independence of the cause bits can be observed.

// File: rtl/pg_perm_pkg.sv
package pg_perm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  localparam int P_R = 0;
  localparam int P_W = 1;
  localparam int P_X = 2;

  localparam int C_PROT  = 0;
  localparam int C_STORE = 1;
  localparam int C_CKEY  = 2;
  localparam int C_NXG   = 3;
endpackage

// File: rtl/pg_pp_decode.sv
module pg_pp_decode (
  input  logic       key,
  input  logic [2:0] code,
  output logic [2:0] perm
);
  always_comb begin
    perm = 3'b000;
    if (!key) begin
      unique case (code)
        3'd0, 3'd1, 3'd2: perm = 3'b111;
        3'd3, 3'd6:       perm = 3'b101;
        default:          perm = 3'b000;
      endcase
    end else begin
      unique case (code)
        3'd1, 3'd3: perm = 3'b101;
        3'd2:       perm = 3'b111;
        default:    perm = 3'b000;
      endcase
    end
  end
endmodule

// File: rtl/pg_ckey_mask.sv
module pg_ckey_mask #(
  parameter int KEY_W = 5,
  localparam int NKEYS = 1 << KEY_W,
  localparam int MASK_W = 2 * NKEYS
) (
  input  logic [KEY_W-1:0]  key,
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] fetch_mask,
  input  logic              data_en,
  input  logic              fetch_en,
  output logic [2:0]        perm
);
  // Pair for key k starts at 2*(NKEYS-1-k); NKEYS-1-k equals ~k.
  logic [KEY_W:0] lo_idx, hi_idx;
  assign lo_idx = {~key, 1'b0};
  assign hi_idx = {~key, 1'b1};

  always_comb begin
    perm[0] = !(data_en && data_mask[lo_idx]);
    perm[1] = !(data_en && data_mask[hi_idx]);
    perm[2] = !(fetch_en && fetch_mask[lo_idx]);
  end
endmodule

// File: rtl/pg_fault_enc.sv
module pg_fault_enc
  import pg_perm_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [2:0] pp_perm,
  input  logic [2:0] nx_perm,
  input  logic [2:0] ck_perm,
  output logic [2:0] comb_perm,
  output logic       grant,
  output logic [3:0] cause
);
  logic [2:0] need;
  logic       is_fetch, is_store;

  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    need = 3'b000;
    if (is_fetch)      need[P_X] = 1'b1;
    else if (is_store) need[P_W] = 1'b1;
    else               need[P_R] = 1'b1;
  end

  assign comb_perm = pp_perm & nx_perm & ck_perm;
  assign grant     = |(need & comb_perm);

  always_comb begin
    cause = 4'b0000;
    if (!grant) begin
      if (is_fetch) begin
        cause[C_NXG]  = !nx_perm[P_X];
        cause[C_PROT] = nx_perm[P_X] && !pp_perm[P_X];
        cause[C_CKEY] = !ck_perm[P_X];
      end else begin
        cause[C_PROT]  = |(need & ~pp_perm);
        cause[C_STORE] = is_store;
        cause[C_CKEY]  = |(need & ~ck_perm);
      end
    end
  end
endmodule

// File: rtl/pg_perm_eval.sv
module pg_perm_eval
  import pg_perm_pkg::*;
#(
  parameter int KEY_W        = 5,
  parameter int LVL_W        = 2,
  parameter int CKEY_MIN_LVL = 1,
  parameter int XMASK_MIN_LVL = 2,
  localparam int MASK_W = 2 * (1 << KEY_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        acc_type,
  input  logic              prob_state,
  input  logic              seg_key_user,
  input  logic              seg_key_sup,
  input  logic [1:0]        pp_lo,
  input  logic              pp_hi,
  input  logic              no_exec,
  input  logic              guarded,
  input  logic [KEY_W-1:0]  page_ckey,
  input  logic [MASK_W-1:0] ckey_data_mask,
  input  logic [MASK_W-1:0] ckey_fetch_mask,
  input  logic [LVL_W-1:0]  mmu_level,
  input  logic              ref_in,
  input  logic              chg_in,
  output logic              rsp_valid,
  output logic [2:0]        perm,
  output logic              grant,
  output logic [3:0]        cause,
  output logic              ref_out,
  output logic              chg_out,
  output logic              wb_req
);
  localparam logic [LVL_W-1:0] CK_LVL = LVL_W'(CKEY_MIN_LVL);
  localparam logic [LVL_W-1:0] XM_LVL = LVL_W'(XMASK_MIN_LVL);

  logic       key_sel;
  logic [2:0] pp_perm, nx_perm, ck_perm, comb_perm;
  logic       grant_c;
  logic [3:0] cause_c;
  logic [2:0] perm_c;
  logic       ref_c, chg_c, wb_c, is_store;

  assign key_sel  = prob_state ? seg_key_user : seg_key_sup;
  assign nx_perm  = (no_exec || guarded) ? 3'b011 : 3'b111;
  assign is_store = (acc_type == ACC_STORE);

  pg_pp_decode u_pp (
    .key  (key_sel),
    .code ({pp_hi, pp_lo}),
    .perm (pp_perm)
  );

  pg_ckey_mask #(.KEY_W(KEY_W)) u_ck (
    .key        (page_ckey),
    .data_mask  (ckey_data_mask),
    .fetch_mask (ckey_fetch_mask),
    .data_en    (mmu_level >= CK_LVL),
    .fetch_en   (mmu_level >= XM_LVL),
    .perm       (ck_perm)
  );

  pg_fault_enc u_fe (
    .acc       (acc_type),
    .pp_perm   (pp_perm),
    .nx_perm   (nx_perm),
    .ck_perm   (ck_perm),
    .comb_perm (comb_perm),
    .grant     (grant_c),
    .cause     (cause_c)
  );

  always_comb begin
    perm_c = comb_perm;
    ref_c  = ref_in;
    chg_c  = chg_in;
    if (grant_c) begin
      ref_c = 1'b1;
      chg_c = chg_in | is_store;
      if (!is_store) perm_c[P_W] = 1'b0;
    end
    wb_c = grant_c && ((ref_c != ref_in) || (chg_c != chg_in));
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      perm      <= 3'b000;
      grant     <= 1'b0;
      cause     <= 4'b0000;
      ref_out   <= 1'b0;
      chg_out   <= 1'b0;
      wb_req    <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      perm      <= perm_c;
      grant     <= grant_c;
      cause     <= cause_c;
      ref_out   <= ref_c;
      chg_out   <= chg_c;
      wb_req    <= wb_c;
    end
  end
endmodule

// File: rtl/pg_perm_chk.sv
module pg_perm_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] acc_type,
  input logic       rsp_valid,
  input logic [2:0] perm,
  input logic       grant,
  input logic [3:0] cause,
  input logic       ref_out,
  input logic       wb_req
);
  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!grant && cause == 4'b0000 && !wb_req));

  // R10
  grant_sets_ref_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> (ref_out && cause == 4'b0000));

  // R10
  wb_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> grant);

  // R10
  nonstore_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && $past(acc_type) != 2'd1) |-> !perm[1]);

  // R8
  deny_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !grant) |-> (cause != 4'b0000));
endmodule

bind pg_perm_eval pg_perm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .acc_type  (acc_type),
  .rsp_valid (rsp_valid),
  .perm      (perm),
  .grant     (grant),
  .cause     (cause),
  .ref_out   (ref_out),
  .wb_req    (wb_req)
);

// File: tb/tb_pg_perm_eval.sv
`timescale 1ns/1ps
module tb_pg_perm_eval;
  localparam int KEY_W = 5;
  localparam int LVL_W = 2;
  localparam int MASK_W = 2 * (1 << KEY_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] acc_type = '0;
  logic prob_state = 1'b0, seg_key_user = 1'b0, seg_key_sup = 1'b0;
  logic [1:0] pp_lo = '0;
  logic pp_hi = 1'b0, no_exec = 1'b0, guarded = 1'b0;
  logic [KEY_W-1:0] page_ckey = '0;
  logic [MASK_W-1:0] ckey_data_mask = '0, ckey_fetch_mask = '0;
  logic [LVL_W-1:0] mmu_level = '0;
  logic ref_in = 1'b0, chg_in = 1'b0;
  logic rsp_valid, grant, ref_out, chg_out, wb_req;
  logic [2:0] perm;
  logic [3:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_perm_eval dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .acc_type(acc_type),
    .prob_state(prob_state), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
    .pp_lo(pp_lo), .pp_hi(pp_hi), .no_exec(no_exec), .guarded(guarded),
    .page_ckey(page_ckey), .ckey_data_mask(ckey_data_mask),
    .ckey_fetch_mask(ckey_fetch_mask), .mmu_level(mmu_level),
    .ref_in(ref_in), .chg_in(chg_in), .rsp_valid(rsp_valid), .perm(perm),
    .grant(grant), .cause(cause), .ref_out(ref_out), .chg_out(chg_out),
    .wb_req(wb_req)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] acc;
    logic       pr, ku, ks;
    logic [2:0] code;
    logic       nx, g, ri, ci;
    logic [2:0] ep;
    logic       eg;
    logic [3:0] ec;
    logic       er, ech, ew;
  } vec_t;

  // cause = {nxg, ckey, store, prot}; perm = {x, w, r}
  localparam vec_t TBL [16] = '{
    '{4'd2,  2'd0, 1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b0, 1'b0,1'b0, 3'b101, 1'b1, 4'b0000, 1'b1,1'b0,1'b1}, // R2 R10
    '{4'd2,  2'd1, 1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b0, 1'b1,1'b0, 3'b111, 1'b1, 4'b0000, 1'b1,1'b1,1'b1}, // R2 R10
    '{4'd9,  2'd1, 1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b0, 1'b0,1'b0, 3'b101, 1'b0, 4'b0011, 1'b0,1'b0,1'b0}, // R9
    '{4'd3,  2'd2, 1'b1,1'b1,1'b0, 3'd0, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0001, 1'b0,1'b0,1'b0}, // R3 R8
    '{4'd3,  2'd2, 1'b1,1'b1,1'b0, 3'd6, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0001, 1'b0,1'b0,1'b0}, // R3
    '{4'd2,  2'd2, 1'b0,1'b1,1'b0, 3'd6, 1'b0,1'b0, 1'b1,1'b1, 3'b101, 1'b1, 4'b0000, 1'b1,1'b1,1'b0}, // R2 R10
    '{4'd8,  2'd2, 1'b0,1'b0,1'b0, 3'd1, 1'b1,1'b0, 1'b0,1'b0, 3'b011, 1'b0, 4'b1000, 1'b0,1'b0,1'b0}, // R4 R8
    '{4'd4,  2'd0, 1'b0,1'b0,1'b0, 3'd1, 1'b0,1'b1, 1'b1,1'b0, 3'b001, 1'b1, 4'b0000, 1'b1,1'b0,1'b0}, // R4 R10
    '{4'd3,  2'd1, 1'b1,1'b1,1'b0, 3'd2, 1'b0,1'b0, 1'b0,1'b0, 3'b111, 1'b1, 4'b0000, 1'b1,1'b1,1'b1}, // R3
    '{4'd3,  2'd0, 1'b1,1'b1,1'b0, 3'd3, 1'b0,1'b0, 1'b0,1'b0, 3'b101, 1'b1, 4'b0000, 1'b1,1'b0,1'b1}, // R3
    '{4'd1,  2'd0, 1'b1,1'b0,1'b1, 3'd4, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0001, 1'b0,1'b0,1'b0}, // R1
    '{4'd1,  2'd0, 1'b0,1'b1,1'b1, 3'd0, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0001, 1'b0,1'b0,1'b0}, // R1
    '{4'd2,  2'd1, 1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0011, 1'b0,1'b0,1'b0}, // R2 R9
    '{4'd8,  2'd2, 1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b1, 1'b0,1'b0, 3'b011, 1'b0, 4'b1000, 1'b0,1'b0,1'b0}, // R4 R8
    '{4'd3,  2'd0, 1'b1,1'b1,1'b0, 3'd7, 1'b0,1'b0, 1'b0,1'b0, 3'b000, 1'b0, 4'b0001, 1'b0,1'b0,1'b0}, // R3
    '{4'd7,  2'd3, 1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b0, 1'b0,1'b0, 3'b101, 1'b1, 4'b0000, 1'b1,1'b0,1'b1}  // R7
  };

  task automatic run(input int rq, input logic [1:0] acc, input logic pr, ku, ks,
                     input logic [2:0] code, input logic nx, g,
                     input logic [KEY_W-1:0] key, input logic [MASK_W-1:0] dm, fm,
                     input logic [LVL_W-1:0] lvl, input logic ri, ci,
                     input logic [2:0] ep, input logic eg, input logic [3:0] ec,
                     input logic er, ech, ew);
    logic [11:0] act, exp_v;
    acc_type = acc; prob_state = pr; seg_key_user = ku; seg_key_sup = ks;
    pp_hi = code[2]; pp_lo = code[1:0]; no_exec = nx; guarded = g;
    page_ckey = key; ckey_data_mask = dm; ckey_fetch_mask = fm;
    mmu_level = lvl; ref_in = ri; chg_in = ci; req_valid = 1'b1;
    @(negedge clk);
    act   = {rsp_valid, perm, grant, cause, ref_out, chg_out, wb_req};
    exp_v = {1'b1, ep, eg, ec, er, ech, ew};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL R%0d: {v,perm,grant,cause,ref,chg,wb} actual=%b expected=%b", rq, act, exp_v);
    end
    req_valid = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [MASK_W-1:0] z;
    z = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if ({rsp_valid, grant, wb_req} !== 3'b000) begin
      failures++;
      $display("FAIL R11: actual=%b expected=000", {rsp_valid, grant, wb_req});
    end
    rst = 1'b0;
    @(negedge clk);
    // R7: no request yields quiet outputs
    checks++;
    if ({rsp_valid, perm, grant, cause, wb_req} !== 10'd0) begin
      failures++;
      $display("FAIL R7 idle: actual=%b expected=0", {rsp_valid, perm, grant, cause, wb_req});
    end

    for (int i = 0; i < 16; i++) begin
      run(int'(TBL[i].rq), TBL[i].acc, TBL[i].pr, TBL[i].ku, TBL[i].ks, TBL[i].code,
          TBL[i].nx, TBL[i].g, '0, z, z, 2'd0, TBL[i].ri, TBL[i].ci,
          TBL[i].ep, TBL[i].eg, TBL[i].ec, TBL[i].er, TBL[i].ech, TBL[i].ew);
    end

    // R5: level 0 ignores a full data mask
    run(5, 2'd1, 0,0,0, 3'd2, 0,0, 5'd3, '1, z, 2'd0, 0,0, 3'b111, 1, 4'b0000, 1,1,1);
    // R5 R9: key 3 store-block bit 57
    run(5, 2'd1, 0,0,0, 3'd2, 0,0, 5'd3, z | (64'd1 << 57), z, 2'd1, 0,0, 3'b101, 0, 4'b0110, 0,0,0);
    run(5, 2'd0, 0,0,0, 3'd2, 0,0, 5'd3, z | (64'd1 << 57), z, 2'd1, 0,0, 3'b101, 1, 4'b0000, 1,0,1);
    // R5 R9: key 3 load-block bit 56
    run(9, 2'd0, 0,0,0, 3'd2, 0,0, 5'd3, z | (64'd1 << 56), z, 2'd1, 0,0, 3'b110, 0, 4'b0100, 0,0,0);
    run(5, 2'd1, 0,0,0, 3'd2, 0,0, 5'd3, z | (64'd1 << 56), z, 2'd1, 0,0, 3'b110, 1, 4'b0000, 1,1,1);
    // R5: key 31 uses bits 1:0, key 0 uses bits 63:62
    run(5, 2'd0, 0,0,0, 3'd0, 0,0, 5'd31, z | 64'd1, z, 2'd1, 0,0, 3'b110, 0, 4'b0100, 0,0,0);
    run(5, 2'd0, 0,0,0, 3'd0, 0,0, 5'd31, z | (64'd1 << 62), z, 2'd1, 1,0, 3'b101, 1, 4'b0000, 1,0,0);
    run(5, 2'd0, 0,0,0, 3'd0, 0,0, 5'd0, z | (64'd1 << 62), z, 2'd1, 0,0, 3'b110, 0, 4'b0100, 0,0,0);
    // R6: fetch mask ignored at level 1, applied at 2 and 3
    run(6, 2'd2, 0,0,0, 3'd0, 0,0, 5'd3, z, z | (64'd1 << 56), 2'd1, 1,1, 3'b101, 1, 4'b0000, 1,1,0);
    run(6, 2'd2, 0,0,0, 3'd0, 0,0, 5'd3, z, z | (64'd1 << 56), 2'd2, 0,0, 3'b011, 0, 4'b0100, 0,0,0);
    // R8: no-exec and class key together
    run(8, 2'd2, 0,0,0, 3'd0, 1,0, 5'd3, z, z | (64'd1 << 56), 2'd3, 0,0, 3'b011, 0, 4'b1100, 0,0,0);
    // R8: protection and class key together
    run(8, 2'd2, 1,1,0, 3'd0, 0,0, 5'd3, z, z | (64'd1 << 56), 2'd2, 0,0, 3'b000, 0, 4'b0101, 0,0,0);

    @(negedge clk);
    finish_up();
  end
endmodule